// File: doc/BRIEF.md
# Single-Lane High-Speed Burst Sequencer

This block drives the transmit side of one serial display data lane. It sends one packet per burst and supports no escape mode. A requester hands over a packet header and, for long packets, a checksum. The block then takes the lane out of low-power idle through the two intermediate line states. It enables the high-speed driver, sends a zero leader and the sync byte, and streams the packet bytes. It closes with an HS trail and returns the lane to idle.

The outputs go straight to an external pad and DDR serializer. These outputs are the two single-ended low-power line levels, an HS driver enable and one parallel byte per byte-clock cycle. Long-packet payload is pulled from a ready/valid byte source during the burst. A source that cannot keep up is flagged, and the burst keeps its timing. Every timing interval is given as a minimum in picoseconds together with the byte-clock period. The block rounds each interval up to whole byte-clock cycles.

Top module: `hs_lane_seq`

## Requirements
- R1: Out of reset and between bursts the lane is LP-11 (`lp_p`=1, `lp_n`=1), `hs_en` is 0 and `req_ready` is 1.
- R2: After a request is accepted, `lp_p` falls first while `lp_n` stays high (LP-01). This lasts exactly ceil(TLPX_PS/BYTE_CLK_PS) cycles, which is 10 at the defaults.
- R3: `lp_n` then falls (LP-00) and both lines stay low with `hs_en`=0 for exactly ceil(PREP_PS/BYTE_CLK_PS) cycles, which is 19 at the defaults, before `hs_en` rises.
- R4: The first HS bytes are ceil(ZERO_PS/BYTE_CLK_PS) bytes of 0x00, which is 8 at the defaults, followed by one byte 0xB8.
- R5: A short packet (`req_long`=0) sends the four bytes of `req_hdr` least significant byte first: [7:0] data type, [15:8], [23:16], then [31:24] ECC.
- R6: A long packet (`req_long`=1) sends the four header bytes in the same order. Its word count is `req_hdr[23:8]`. It is followed by exactly that many payload bytes taken from `pay_data`, and then by `req_csum` low byte first. A word count of 0 sends no payload, and a checksum of 0x0000 is sent like any other value.
- R7: `hs_byte` bit 0 is the first bit on the wire when WIRE_MSB_FIRST=0, which is the default. When WIRE_MSB_FIRST=1 the byte is bit-reversed.
- R8: After the last packet byte, every byte is all copies of the inverse of bit 7 of that last byte. This trail lasts ceil(TRAIL_PS/BYTE_CLK_PS) cycles, which is 9 at the defaults, and then `hs_en` drops.
- R9: `done` is a one-cycle pulse in the first cycle after the trail, with the lane already back at LP-11.
- R10: If `pay_valid` is 0 in a cycle with `pay_ready`=1, the block sends 0x00 in that payload slot and sets `stall_err`. The next payload slot takes the withheld byte. `stall_err` stays set until the next request is accepted.
- R11: `hs_en` is 1 only while both LP lines are low, and `pay_ready` is 1 only inside HS bursts during payload slots.
- R12: While a burst is in progress `req_ready` is 0 and `req_valid` is ignored. The bytes of the running burst are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Packet request |
| req_ready | output | 1 | Idle, request accepted this cycle if valid |
| req_long | input | 1 | 1 = long packet |
| req_hdr | input | 32 | Header bytes, byte 0 sent first |
| req_csum | input | 16 | Long-packet checksum |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte consumed this cycle |
| pay_data | input | 8 | Payload byte |
| lp_p | output | 1 | Low-power level of the positive line |
| lp_n | output | 1 | Low-power level of the negative line |
| hs_en | output | 1 | HS driver enable |
| hs_byte | output | 8 | Parallel byte for the serializer |
| done | output | 1 | Burst finished pulse |
| stall_err | output | 1 | Payload source stalled during the last burst |

## Verification
The bound checker watches the line-state order on every cycle. It checks that the positive line falls first, that HS is only enabled with both lines low, and that the minimum LP-01 and LP-00 durations hold. It also checks that HS opens on a zero byte, that payload is requested only inside HS, and that `done` is a single pulse seen at LP-11. The exact byte stream can only be shown by the bench's scenarios. This covers header byte order, word-count-driven payload length, checksum placement, trail polarity, the exact rounded interval lengths, the substitution after a stall and the ignoring of requests during a burst. The scenarios cover short packets, long packets with a zero and a nonzero word count, and both trail polarities.

// File: rtl/hs_lane_pkg.sv
package hs_lane_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_LP01, ST_LP00, ST_ZERO, ST_SYNC,
      ST_HDR, ST_PAY, ST_CSUM, ST_TRAIL
   } seq_state_t;

   localparam logic [7:0] SYNC_BYTE = 8'hB8;
   localparam int WC_W = 16;

   // whole cycles covering a minimum interval, never fewer than one
   function automatic int cyc_ceil(input int span_ps, input int per_ps);
      int c;
      c = (span_ps + per_ps - 1) / per_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int bits_for(input int v);
      int b;
      b = 1;
      while ((1 << b) <= v) b++;
      return b;
   endfunction
endpackage

// File: rtl/hs_seq_timer.sv
module hs_seq_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count,
   output logic         at_zero
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            count <= '0;
      else if (load)         count <= load_val;
      else if (count != '0)  count <= count - 1'b1;
   end

   assign at_zero = (count == '0);
endmodule

// File: rtl/hs_byte_path.sv
module hs_byte_path
   import hs_lane_pkg::*;
#(
   parameter bit WIRE_MSB_FIRST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_t state,
   input  logic [1:0] slot,
   input  logic [31:0] hdr,
   input  logic [15:0] csum,
   input  logic [7:0] pay_data,
   input  logic       pay_valid,
   output logic [7:0] hs_byte
);
   logic [7:0] logical;
   logic       last_bit;

   always_comb begin
      unique case (state)
         ST_SYNC:  logical = SYNC_BYTE;
         ST_HDR: begin
            unique case (slot)
               2'd3:    logical = hdr[7:0];
               2'd2:    logical = hdr[15:8];
               2'd1:    logical = hdr[23:16];
               default: logical = hdr[31:24];
            endcase
         end
         ST_PAY:   logical = pay_valid ? pay_data : 8'h00;
         ST_CSUM:  logical = slot[0] ? csum[7:0] : csum[15:8];
         ST_TRAIL: logical = {8{~last_bit}};
         default:  logical = 8'h00;
      endcase
   end

   // the final wire bit of a packet byte is its bit 7
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_bit <= 1'b0;
      else if (state inside {ST_SYNC, ST_HDR, ST_PAY, ST_CSUM})
         last_bit <= logical[7];
   end

   generate
      if (WIRE_MSB_FIRST) begin : g_rev
         for (genvar i = 0; i < 8; i++) begin : g_bit
            assign hs_byte[i] = logical[7-i];
         end
      end else begin : g_fwd
         assign hs_byte = logical;
      end
   endgenerate
endmodule

// File: rtl/hs_lane_seq.sv
module hs_lane_seq
   import hs_lane_pkg::*;
#(
   parameter int BYTE_CLK_PS    = 5000,
   parameter int TLPX_PS        = 50000,
   parameter int PREP_PS        = 95000,
   parameter int ZERO_PS        = 40000,
   parameter int TRAIL_PS       = 42000,
   parameter bit WIRE_MSB_FIRST = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic        req_long,
   input  logic [31:0] req_hdr,
   input  logic [15:0] req_csum,
   input  logic        pay_valid,
   output logic        pay_ready,
   input  logic [7:0]  pay_data,
   output logic        lp_p,
   output logic        lp_n,
   output logic        hs_en,
   output logic [7:0]  hs_byte,
   output logic        done,
   output logic        stall_err
);
   localparam int TLPX_CYC  = cyc_ceil(TLPX_PS,  BYTE_CLK_PS);
   localparam int PREP_CYC  = cyc_ceil(PREP_PS,  BYTE_CLK_PS);
   localparam int ZERO_CYC  = cyc_ceil(ZERO_PS,  BYTE_CLK_PS);
   localparam int TRAIL_CYC = cyc_ceil(TRAIL_PS, BYTE_CLK_PS);
   localparam int MAX_CYC   = (TLPX_CYC > PREP_CYC ? TLPX_CYC : PREP_CYC) >
                              (ZERO_CYC > TRAIL_CYC ? ZERO_CYC : TRAIL_CYC) ?
                              (TLPX_CYC > PREP_CYC ? TLPX_CYC : PREP_CYC) :
                              (ZERO_CYC > TRAIL_CYC ? ZERO_CYC : TRAIL_CYC);
   localparam int TW = bits_for(MAX_CYC) > WC_W ? bits_for(MAX_CYC) : WC_W;

   generate
      if (BYTE_CLK_PS <= 0) begin : g_bad_period
         $error("BYTE_CLK_PS must be positive");
      end
      if (TLPX_PS < 0 || PREP_PS < 0 || ZERO_PS < 0 || TRAIL_PS < 0) begin : g_bad_span
         $error("interval minimums must not be negative");
      end
   endgenerate

   seq_state_t        state, nxt;
   logic              ld;
   logic [TW-1:0]     ld_val, cnt;
   logic              cnt_zero;
   logic              pkt_long;
   logic [31:0]       pkt_hdr;
   logic [15:0]       pkt_csum;
   logic [WC_W-1:0]   wc;

   assign wc = pkt_hdr[23:8];

   always_comb begin
      nxt    = state;
      ld     = 1'b0;
      ld_val = '0;
      unique case (state)
         ST_IDLE: if (req_valid) begin
            nxt = ST_LP01; ld = 1'b1; ld_val = TW'(TLPX_CYC - 1);
         end
         ST_LP01: if (cnt_zero) begin
            nxt = ST_LP00; ld = 1'b1; ld_val = TW'(PREP_CYC - 1);
         end
         ST_LP00: if (cnt_zero) begin
            nxt = ST_ZERO; ld = 1'b1; ld_val = TW'(ZERO_CYC - 1);
         end
         ST_ZERO: if (cnt_zero) nxt = ST_SYNC;
         ST_SYNC: begin
            nxt = ST_HDR; ld = 1'b1; ld_val = TW'(3);
         end
         ST_HDR: if (cnt_zero) begin
            ld = 1'b1;
            if (pkt_long && wc != '0) begin
               nxt = ST_PAY; ld_val = TW'(wc - 1'b1);
            end else if (pkt_long) begin
               nxt = ST_CSUM; ld_val = TW'(1);
            end else begin
               nxt = ST_TRAIL; ld_val = TW'(TRAIL_CYC - 1);
            end
         end
         ST_PAY: if (cnt_zero) begin
            nxt = ST_CSUM; ld = 1'b1; ld_val = TW'(1);
         end
         ST_CSUM: if (cnt_zero) begin
            nxt = ST_TRAIL; ld = 1'b1; ld_val = TW'(TRAIL_CYC - 1);
         end
         ST_TRAIL: if (cnt_zero) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pkt_long  <= 1'b0;
         pkt_hdr   <= '0;
         pkt_csum  <= '0;
         done      <= 1'b0;
         stall_err <= 1'b0;
      end else begin
         state <= nxt;
         done  <= (state == ST_TRAIL) && cnt_zero;
         if (state == ST_IDLE && req_valid) begin
            pkt_long  <= req_long;
            pkt_hdr   <= req_hdr;
            pkt_csum  <= req_csum;
            stall_err <= 1'b0;
         end else if (state == ST_PAY && !pay_valid) begin
            stall_err <= 1'b1;
         end
      end
   end

   hs_seq_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .count    (cnt),
      .at_zero  (cnt_zero)
   );

   hs_byte_path #(.WIRE_MSB_FIRST(WIRE_MSB_FIRST)) u_bytes (
      .clk       (clk),
      .rst_n     (rst_n),
      .state     (state),
      .slot      (cnt[1:0]),
      .hdr       (pkt_hdr),
      .csum      (pkt_csum),
      .pay_data  (pay_data),
      .pay_valid (pay_valid),
      .hs_byte   (hs_byte)
   );

   assign req_ready = (state == ST_IDLE);
   assign lp_p      = (state == ST_IDLE);
   assign lp_n      = (state == ST_IDLE) || (state == ST_LP01);
   assign hs_en     = state inside {ST_ZERO, ST_SYNC, ST_HDR, ST_PAY, ST_CSUM, ST_TRAIL};
   assign pay_ready = (state == ST_PAY);
endmodule

// File: rtl/hs_lane_seq_chk.sv
module hs_lane_seq_chk
   import hs_lane_pkg::*;
#(
   parameter int BYTE_CLK_PS = 5000,
   parameter int TLPX_PS     = 50000,
   parameter int PREP_PS     = 95000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       pay_ready,
   input logic       lp_p,
   input logic       lp_n,
   input logic       hs_en,
   input logic [7:0] hs_byte,
   input logic       done
);
   localparam int TLPX_MIN = cyc_ceil(TLPX_PS, BYTE_CLK_PS);
   localparam int PREP_MIN = cyc_ceil(PREP_PS, BYTE_CLK_PS);

   logic [15:0] run01, run00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run01 <= '0;
         run00 <= '0;
      end else begin
         run01 <= (!lp_p && lp_n) ? ((run01 == 16'hFFFF) ? run01 : run01 + 1'b1) : '0;
         run00 <= (!lp_p && !lp_n && !hs_en) ? ((run00 == 16'hFFFF) ? run00 : run00 + 1'b1) : '0;
      end
   end

   AST_IDLE_LP11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (lp_p && lp_n && !hs_en)); // R1
   AST_DP_FALLS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lp_p) |-> lp_n); // R2
   AST_TLPX_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lp_n) |-> (run01 >= 16'(TLPX_MIN))); // R2
   AST_PREP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> (run00 >= 16'(PREP_MIN))); // R3
   AST_ZERO_LEADER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> (hs_byte == 8'h00)); // R4
   AST_HS_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en |-> (!lp_p && !lp_n)); // R11
   AST_PAY_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
      pay_ready |-> hs_en); // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
   AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lp_p && lp_n && !hs_en)); // R9
endmodule

bind hs_lane_seq hs_lane_seq_chk #(
   .BYTE_CLK_PS (BYTE_CLK_PS),
   .TLPX_PS     (TLPX_PS),
   .PREP_PS     (PREP_PS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .pay_ready (pay_ready),
   .lp_p      (lp_p),
   .lp_n      (lp_n),
   .hs_en     (hs_en),
   .hs_byte   (hs_byte),
   .done      (done)
);

// File: tb/hs_lane_seq_bench.sv
`timescale 1ns/1ps
module hs_lane_seq_bench;
   localparam int N01 = 10, N00 = 19, NZERO = 8, NTRAIL = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_long = 1'b0;
   logic [31:0] req_hdr = '0;
   logic [15:0] req_csum = '0;
   logic pay_valid, pay_ready;
   logic [7:0] pay_data;
   logic req_ready, lp_p, lp_n, hs_en, done, stall_err;
   logic [7:0] hs_byte;

   int tests = 0, fails = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] pay_mem [0:15];
   int  pay_idx = 0;
   int  stall_at_v = -1;
   bit  stall_req = 0, stall_left = 0, pay_clr = 0;
   bit  done_seen = 0;
   int  c01 = 0, c00 = 0;
   bit  prev_hs = 0;

   always #2.5 clk = ~clk;

   hs_lane_seq u_hs_lane_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_long(req_long), .req_hdr(req_hdr), .req_csum(req_csum),
      .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
      .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en), .hs_byte(hs_byte),
      .done(done), .stall_err(stall_err)
   );

   assign pay_data  = pay_mem[pay_idx[3:0]];
   assign pay_valid = !(stall_left && pay_idx == stall_at_v);

   always @(posedge clk) begin
      if (pay_clr) begin
         pay_idx    <= 0;
         stall_left <= stall_req;
      end else if (pay_ready) begin
         if (pay_valid) pay_idx <= pay_idx + 1;
         else           stall_left <= 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: line-state durations and scoreboard of HS bytes
   always @(negedge clk) begin
      if (rst_n) begin
         if (!lp_p && lp_n) c01++;
         if (!lp_p && !lp_n && !hs_en) c00++;
         if (hs_en && !prev_hs) begin
            check(c01 == N01, "R2 LP-01 cycles", c01, N01);
            check(c00 == N00, "R3 LP-00 cycles", c00, N00);
            c01 = 0; c00 = 0;
         end
         if (hs_en) begin
            if (exp_q.size() == 0) check(0, "R8 unexpected HS byte", hs_byte, 0);
            else begin
               automatic logic [7:0] e = exp_q.pop_front();
               automatic string t = tag_q.pop_front();
               check(hs_byte == e, t, hs_byte, e);
            end
         end
         if (done) begin
            check(lp_p && lp_n && !hs_en && req_ready, "R9 done at LP-11", {lp_p, lp_n, hs_en}, 3'b110);
            check(exp_q.size() == 0, "R8 stream complete at done", exp_q.size(), 0);
            done_seen = 1;
         end
         prev_hs = hs_en;
      end
   end

   task automatic push(input logic [7:0] b, input string t);
      exp_q.push_back(b);
      tag_q.push_back(t);
   endtask

   task automatic run_pkt(input bit lng, input logic [31:0] hdr, input logic [15:0] cs,
                          input int stall_at, input bit poke_busy);
      int wc, k;
      logic last7;
      wc = lng ? int'(hdr[23:8]) : 0;
      for (int i = 0; i < NZERO; i++) push(8'h00, "R4 zero leader");
      push(8'hB8, "R4 sync byte");
      for (int i = 0; i < 4; i++) push(hdr[8*i +: 8], lng ? "R6 header byte" : "R5 header byte");
      k = 0;
      for (int i = 0; i < wc; i++) begin
         if (i == stall_at) push(8'h00, "R10 stalled slot");
         else begin
            push(pay_mem[k], "R6 payload byte");
            k++;
         end
      end
      if (lng) begin
         push(cs[7:0], "R6 checksum low");
         push(cs[15:8], "R6 checksum high");
      end
      last7 = lng ? cs[15] : hdr[31];
      for (int i = 0; i < NTRAIL; i++) push({8{~last7}}, "R8 trail byte");

      @(negedge clk);
      check(req_ready && lp_p && lp_n && !hs_en, "R1 idle before request", {req_ready, lp_p, lp_n, hs_en}, 4'b1110);
      pay_clr = 1; stall_req = (stall_at >= 0); stall_at_v = stall_at;
      done_seen = 0;
      req_valid = 1; req_long = lng; req_hdr = hdr; req_csum = cs;
      @(negedge clk);
      pay_clr = 0; req_valid = 0;
      check(!lp_p && lp_n, "R2 positive line falls first", {lp_p, lp_n}, 2'b01);
      if (poke_busy) begin
         req_valid = 1; req_long = 0; req_hdr = 32'hDEAD_BEEF;
         for (int i = 0; i < 4; i++) begin
            check(!req_ready, "R12 busy not ready", req_ready, 0);
            @(negedge clk);
         end
         req_valid = 0;
      end
      while (!done_seen) @(negedge clk);
      @(negedge clk);
      check(!done, "R9 done is one cycle", done, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) pay_mem[i] = 8'(8'h31 + 8'(i * 7));
      repeat (3) @(negedge clk);
      check(lp_p && lp_n && !hs_en && req_ready && !done && !pay_ready && !stall_err,
            "R1 reset state", {lp_p, lp_n, hs_en, req_ready, done, pay_ready, stall_err}, 7'b1101000);
      rst_n = 1;
      // short packet, ECC bit 7 clear: trail of ones, bit 0 first on wire (R7)
      run_pkt(0, 32'h25_00_11_15, 16'h0000, -1, 0);
      // short packet, ECC bit 7 set: trail of zeros
      run_pkt(0, 32'h9A_80_36_15, 16'h0000, -1, 0);
      // long packet, 6 payload bytes, zero checksum, requests poked while busy
      run_pkt(1, 32'h0B_00_06_39, 16'h0000, -1, 1);
      check(!stall_err, "R10 no stall flagged", stall_err, 0);
      // long packet with no payload, checksum bit 15 set
      run_pkt(1, 32'h1C_00_00_39, 16'h8001, -1, 0);
      // long packet with a source stall at payload slot 2
      run_pkt(1, 32'h07_00_05_39, 16'h1234, 2, 0);
      check(stall_err, "R10 stall flagged", stall_err, 1);
      // next accepted request clears the flag
      run_pkt(0, 32'h0F_00_29_05, 16'h0000, -1, 0);
      check(!stall_err, "R10 flag cleared by new request", stall_err, 0);
      check(!pay_ready && !hs_en, "R11 no payload request at idle", {pay_ready, hs_en}, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule